// File: doc/BRIEF.md
# Trimmed Real-Time Clock Seconds Core

This block keeps time for a real-time clock. A single-cycle `tick` strobe arrives once per period of a slow reference, nominally 32.768 kHz. A prescaler counts these ticks. Each time it completes a period, it returns to zero, the seconds counter advances by one and `sec_pulse` is high for one cycle. The prescaler normally runs for `NOMINAL` ticks, which defaults to 32768. A signed 8-bit trim value can shorten or lengthen that period, so a crystal that runs fast or slow can be corrected.

The trim is not applied every second. An 8-bit interval setting N makes the trimmed period apply to one second out of every N+1; all other seconds use the nominal length. Two read-only values show where the schedule stands: the trim in force for the current second, and the number of seconds left before the next trimmed one.

The block compares the seconds count with a 32-bit alarm value. It keeps three sticky flags: time invalid, counter overflow and alarm. While the invalid or overflow flag is set, the seconds count reads as zero and the time does not advance. Bus decoding, register locks and oscillator trim are handled outside this block.

Top module: `rtc_seconds_core`

## Requirements
- R1: After `rst_n` is low: `flag_invalid`=1, `flag_overflow`=0, `flag_alarm`=0, `sec_rdata`=0, `pre_rdata`=0, and the alarm, trim and interval registers, `comp_now` and `comp_left` are all 0.
- R2: The prescaler advances by one on each cycle where `tick`=1, `count_en`=1 and neither the invalid nor the overflow flag is set. In every other cycle it holds its value.
- R3: When the prescaler reaches the last tick of its period, it returns to 0 and the seconds count advances by one. `sec_pulse` is 1 for exactly the cycle in which the new count first appears. With `comp_now`=0 a second lasts `NOMINAL` ticks.
- R4: A second lasts `NOMINAL` minus the two's-complement value of `comp_now` ticks. With the default `NOMINAL`: 0x01 gives 32767, 0x7F gives 32641, 0xFF gives 32769 and 0x80 gives 32896.
- R5: At each end of a second: if `comp_left` is 0, it reloads with the interval register and `comp_now` takes the trim register; otherwise `comp_left` decrements and `comp_now` becomes 0. The trimmed length therefore applies to one second in every interval+1.
- R6: A pulse on `comp_wr` loads the trim and interval registers at any time. It also loads `comp_now` with the new trim and `comp_left` with the new interval, taking priority over the end-of-second update.
- R7: While `flag_invalid` or `flag_overflow` is 1, `sec_rdata` reads 0.
- R8: When the seconds count advances from 0xFFFFFFFF, it wraps to 0 and `flag_overflow` sets. Counting then stops until the seconds value is rewritten.
- R9: `flag_alarm` sets when the count advances to a value equal to the alarm register. It stays set until the alarm register is written.
- R10: With `count_en`=0, `sec_wr` loads the seconds count and clears `flag_invalid` and `flag_overflow`. With `count_en`=1, `sec_wr` has no effect.
- R11: With `count_en`=0, `alarm_wr` loads the alarm register and clears `flag_alarm`. With `count_en`=1, `alarm_wr` has no effect.
- R12: With `count_en`=0, `pre_wr` loads the prescaler. With `count_en`=1, `pre_wr` has no effect.
- R13: `soft_rst`=1 at a clock edge returns every register and flag to its R1 value, including `flag_invalid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous reset request from software |
| tick | input | 1 | One-cycle strobe per reference-clock period |
| count_en | input | 1 | Time counter enable |
| sec_wr | input | 1 | Write strobe for the seconds count |
| sec_wdata | input | 32 | Seconds value to load |
| pre_wr | input | 1 | Write strobe for the prescaler |
| pre_wdata | input | 16 | Prescaler value to load |
| alarm_wr | input | 1 | Write strobe for the alarm register |
| alarm_wdata | input | 32 | Alarm value to load |
| comp_wr | input | 1 | Write strobe for the trim and interval registers |
| comp_val_wdata | input | 8 | Signed trim value to load |
| comp_int_wdata | input | 8 | Trim interval to load |
| sec_rdata | output | 32 | Seconds count, forced to 0 while invalid or overflowed |
| pre_rdata | output | 16 | Prescaler count |
| alarm_rdata | output | 32 | Alarm register |
| comp_val_rdata | output | 8 | Trim register |
| comp_int_rdata | output | 8 | Interval register |
| comp_now | output | 8 | Trim in force for the current second |
| comp_left | output | 8 | Seconds left before the next trimmed second |
| flag_invalid | output | 1 | Time invalid flag |
| flag_overflow | output | 1 | Seconds overflow flag |
| flag_alarm | output | 1 | Alarm flag |
| sec_pulse | output | 1 | One-cycle pulse on each new second |

## Verification
The block is exercised with a positive trim on an interval of two, which shows whether the trim lands on the right second of the cycle, because the gaps between seconds must follow 256, 256, 240. It is then exercised with the most negative trim on an interval of zero, which separates sign handling from magnitude. A further pattern uses a trim of -1 with `tick` arriving only every other cycle, which shows that periods are counted in ticks rather than in clock cycles. The seconds count is preloaded just below the 32-bit limit to expose the wrap, the forced zero read and the halt. Writes made while counting is enabled are tried against all three guarded registers.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;

  localparam int COMP_W = 8;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic alarm;
  } rtc_flags_t;

  // Length of one second in ticks for a given signed trim.
  function automatic logic [31:0] comp_period(input logic [31:0] nominal,
                                              input logic [COMP_W-1:0] trim);
    logic [31:0] trim_ext;
    trim_ext = {{(32-COMP_W){trim[COMP_W-1]}}, trim};
    return nominal - trim_ext;
  endfunction

  // True when a prescaler value is the final tick of the period.
  function automatic logic last_tick(input logic [31:0] pre_ext,
                                     input logic [31:0] period);
    return (pre_ext + 32'd1) >= period;
  endfunction

  // Seconds value after one advance; the carry marks the wrap.
  function automatic logic [32:0] sec_advance(input logic [31:0] sec);
    return {1'b0, sec} + 33'd1;
  endfunction

endpackage

// File: rtl/rtc_comp_sched.sv
module rtc_comp_sched
  import rtc_core_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              comp_wr,
  input  logic [COMP_W-1:0] val_wdata,
  input  logic [COMP_W-1:0] int_wdata,
  input  logic              sec_wrap,
  output logic [COMP_W-1:0] trim_q,
  output logic [COMP_W-1:0] intv_q,
  output logic [COMP_W-1:0] trim_now,
  output logic [COMP_W-1:0] left_q
);

  logic reload_due;
  assign reload_due = (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q   <= '0;
      intv_q   <= '0;
      trim_now <= '0;
      left_q   <= '0;
    end else if (soft_rst) begin
      trim_q   <= '0;
      intv_q   <= '0;
      trim_now <= '0;
      left_q   <= '0;
    end else if (comp_wr) begin
      trim_q   <= val_wdata;
      intv_q   <= int_wdata;
      trim_now <= val_wdata;
      left_q   <= int_wdata;
    end else if (sec_wrap) begin
      if (reload_due) begin
        left_q   <= intv_q;
        trim_now <= trim_q;
      end else begin
        left_q   <= left_q - 1'b1;
        trim_now <= '0;
      end
    end
  end

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_core_pkg::*;
#(
  parameter int PW      = 16,
  parameter int NOMINAL = 32768
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              tick,
  input  logic              run,
  input  logic              load,
  input  logic [PW-1:0]     load_val,
  input  logic [COMP_W-1:0] trim_now,
  output logic [PW-1:0]     pre_q,
  output logic              wrap
);

  localparam logic [31:0] NOM_L = 32'(NOMINAL);

  logic [31:0] period_w;
  logic [31:0] pre_ext;
  logic        at_end;
  logic        step;

  assign period_w = comp_period(NOM_L, trim_now);
  assign pre_ext  = {{(32-PW){1'b0}}, pre_q};
  assign at_end   = last_tick(pre_ext, period_w);
  assign step     = tick & run;
  assign wrap     = step & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (soft_rst) begin
      pre_q <= '0;
    end else if (load) begin
      pre_q <= load_val;
    end else if (step) begin
      pre_q <= at_end ? '0 : pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/rtc_time_keeper.sv
module rtc_time_keeper
  import rtc_core_pkg::*;
#(
  parameter int SW = 32
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          wrap,
  input  logic          sec_load,
  input  logic [SW-1:0] sec_wdata,
  input  logic          alarm_load,
  input  logic [SW-1:0] alarm_wdata,
  output logic [SW-1:0] sec_q,
  output logic [SW-1:0] alarm_q,
  output rtc_flags_t    flags_q,
  output logic          pulse_q
);

  logic [32:0]   adv;
  logic [SW-1:0] sec_next;
  logic          carry;
  logic          hit;

  assign adv      = sec_advance(32'(sec_q));
  assign sec_next = adv[SW-1:0];
  assign carry    = (sec_q == '1);
  assign hit      = (sec_next == alarm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q   <= '0;
      alarm_q <= '0;
      flags_q <= '{invalid: 1'b1, overflow: 1'b0, alarm: 1'b0};
      pulse_q <= 1'b0;
    end else if (soft_rst) begin
      sec_q   <= '0;
      alarm_q <= '0;
      flags_q <= '{invalid: 1'b1, overflow: 1'b0, alarm: 1'b0};
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wrap;
      if (sec_load) begin
        sec_q            <= sec_wdata;
        flags_q.invalid  <= 1'b0;
        flags_q.overflow <= 1'b0;
      end else if (wrap) begin
        sec_q <= sec_next;
        if (carry) flags_q.overflow <= 1'b1;
        if (hit)   flags_q.alarm    <= 1'b1;
      end
      if (alarm_load) begin
        alarm_q       <= alarm_wdata;
        flags_q.alarm <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core
  import rtc_core_pkg::*;
#(
  parameter int PW      = 16,
  parameter int SW      = 32,
  parameter int NOMINAL = 32768
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              tick,
  input  logic              count_en,
  input  logic              sec_wr,
  input  logic [SW-1:0]     sec_wdata,
  input  logic              pre_wr,
  input  logic [PW-1:0]     pre_wdata,
  input  logic              alarm_wr,
  input  logic [SW-1:0]     alarm_wdata,
  input  logic              comp_wr,
  input  logic [COMP_W-1:0] comp_val_wdata,
  input  logic [COMP_W-1:0] comp_int_wdata,
  output logic [SW-1:0]     sec_rdata,
  output logic [PW-1:0]     pre_rdata,
  output logic [SW-1:0]     alarm_rdata,
  output logic [COMP_W-1:0] comp_val_rdata,
  output logic [COMP_W-1:0] comp_int_rdata,
  output logic [COMP_W-1:0] comp_now,
  output logic [COMP_W-1:0] comp_left,
  output logic              flag_invalid,
  output logic              flag_overflow,
  output logic              flag_alarm,
  output logic              sec_pulse
);

  // Named internal events, visible to the bound checker.
  logic          counting;
  logic          pre_wrap;
  logic          sec_load;
  logic          alarm_load;
  logic          pre_load;
  logic [SW-1:0] sec_q;
  rtc_flags_t    flags_q;

  assign counting   = count_en & ~flags_q.invalid & ~flags_q.overflow;
  assign sec_load   = sec_wr   & ~count_en;
  assign alarm_load = alarm_wr & ~count_en;
  assign pre_load   = pre_wr   & ~count_en;

  rtc_prescaler #(.PW(PW), .NOMINAL(NOMINAL)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .tick     (tick),
    .run      (counting),
    .load     (pre_load),
    .load_val (pre_wdata),
    .trim_now (comp_now),
    .pre_q    (pre_rdata),
    .wrap     (pre_wrap)
  );

  rtc_comp_sched u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .comp_wr   (comp_wr),
    .val_wdata (comp_val_wdata),
    .int_wdata (comp_int_wdata),
    .sec_wrap  (pre_wrap),
    .trim_q    (comp_val_rdata),
    .intv_q    (comp_int_rdata),
    .trim_now  (comp_now),
    .left_q    (comp_left)
  );

  rtc_time_keeper #(.SW(SW)) u_time (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .wrap        (pre_wrap),
    .sec_load    (sec_load),
    .sec_wdata   (sec_wdata),
    .alarm_load  (alarm_load),
    .alarm_wdata (alarm_wdata),
    .sec_q       (sec_q),
    .alarm_q     (alarm_rdata),
    .flags_q     (flags_q),
    .pulse_q     (sec_pulse)
  );

  assign flag_invalid  = flags_q.invalid;
  assign flag_overflow = flags_q.overflow;
  assign flag_alarm    = flags_q.alarm;
  assign sec_rdata     = (flags_q.invalid | flags_q.overflow) ? '0 : sec_q;

endmodule

// File: rtl/rtc_seconds_core_chk.sv
module rtc_seconds_core_chk #(
  parameter int PW = 16,
  parameter int SW = 32
)(
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic          count_en,
  input logic          sec_wr,
  input logic          pre_wr,
  input logic          alarm_wr,
  input logic          comp_wr,
  input logic          pre_wrap,
  input logic [SW-1:0] sec_q,
  input logic [SW-1:0] sec_rdata,
  input logic [PW-1:0] pre_rdata,
  input logic [7:0]    comp_val_rdata,
  input logic [7:0]    comp_now,
  input logic [7:0]    comp_left,
  input logic          flag_invalid,
  input logic          flag_overflow,
  input logic          flag_alarm,
  input logic          sec_pulse
);

  assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !pre_wr && !soft_rst) |=> $stable(pre_rdata));

  assert_pulse_follows_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_wrap && !soft_rst) |=> sec_pulse);

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse);

  assert_trim_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_wrap && comp_left == 8'd0 && !comp_wr && !soft_rst)
      |=> comp_now == $past(comp_val_rdata));

  assert_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_invalid || flag_overflow) |-> sec_rdata == '0);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_wrap && sec_q == '1 && !soft_rst) |=> flag_overflow);

  assert_alarm_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_alarm && !alarm_wr && !soft_rst) |=> flag_alarm);

  assert_sec_write_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_wr && count_en && !pre_wrap && !soft_rst) |=> $stable(sec_q));

endmodule

bind rtc_seconds_core rtc_seconds_core_chk #(.PW(PW), .SW(SW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .soft_rst       (soft_rst),
  .count_en       (count_en),
  .sec_wr         (sec_wr),
  .pre_wr         (pre_wr),
  .alarm_wr       (alarm_wr),
  .comp_wr        (comp_wr),
  .pre_wrap       (pre_wrap),
  .sec_q          (sec_q),
  .sec_rdata      (sec_rdata),
  .pre_rdata      (pre_rdata),
  .comp_val_rdata (comp_val_rdata),
  .comp_now       (comp_now),
  .comp_left      (comp_left),
  .flag_invalid   (flag_invalid),
  .flag_overflow  (flag_overflow),
  .flag_alarm     (flag_alarm),
  .sec_pulse      (sec_pulse)
);

// File: tb/rtc_seconds_core_test.sv
module rtc_seconds_core_test;

  localparam int NOM = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        tick = 1'b0;
  logic        count_en = 1'b0;
  logic        sec_wr = 1'b0, pre_wr = 1'b0, alarm_wr = 1'b0, comp_wr = 1'b0;
  logic [31:0] sec_wdata = '0, alarm_wdata = '0;
  logic [15:0] pre_wdata = '0;
  logic [7:0]  comp_val_wdata = '0, comp_int_wdata = '0;
  logic [31:0] sec_rdata, alarm_rdata;
  logic [15:0] pre_rdata;
  logic [7:0]  comp_val_rdata, comp_int_rdata, comp_now, comp_left;
  logic        flag_invalid, flag_overflow, flag_alarm, sec_pulse;

  rtc_seconds_core #(.NOMINAL(NOM)) uut (.*);

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int tick_every = 1;
  bit started = 0;
  int pulses[$];

  // Behavioural reference state
  int      m_pre, m_cv, m_ci, m_cur, m_cnt, m_per;
  longint  m_sec, m_alarm;
  bit      m_inv, m_ovf, m_af, m_pulse, m_run, m_wrap;

  function automatic int sgn8(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    started = 1;
    if (!rst_n || soft_rst) begin
      m_pre = 0; m_cv = 0; m_ci = 0; m_cur = 0; m_cnt = 0;
      m_sec = 0; m_alarm = 0; m_inv = 1; m_ovf = 0; m_af = 0; m_pulse = 0;
    end else begin
      m_per  = NOM - sgn8(m_cur);
      m_run  = count_en && !m_inv && !m_ovf;
      m_wrap = tick && m_run && (m_pre + 1 >= m_per);
      if (comp_wr) begin
        m_cv = comp_val_wdata; m_ci = comp_int_wdata;
        m_cur = comp_val_wdata; m_cnt = comp_int_wdata;
      end else if (m_wrap) begin
        if (m_cnt == 0) begin m_cnt = m_ci; m_cur = m_cv; end
        else begin m_cnt = m_cnt - 1; m_cur = 0; end
      end
      if (!count_en && pre_wr) m_pre = pre_wdata;
      else if (tick && m_run) m_pre = m_wrap ? 0 : m_pre + 1;
      if (!count_en && sec_wr) begin
        m_sec = sec_wdata; m_inv = 0; m_ovf = 0;
      end else if (m_wrap) begin
        m_sec = m_sec + 1;
        if (m_sec > 64'hFFFF_FFFF) begin m_sec = 0; m_ovf = 1; end
        if (m_sec == m_alarm) m_af = 1;
      end
      if (!count_en && alarm_wr) begin m_alarm = alarm_wdata; m_af = 0; end
      m_pulse = m_wrap;
    end
  end

  // Compare on every clock, away from the active edge; then drive tick.
  always @(negedge clk) begin
    cyc++;
    if (started) begin
      check("R2 prescaler", pre_rdata, m_pre);
      check("R7 seconds read", sec_rdata, (m_inv || m_ovf) ? 0 : m_sec);
      check("R11 alarm reg", alarm_rdata, m_alarm);
      check("R6 trim reg", comp_val_rdata, m_cv);
      check("R6 interval reg", comp_int_rdata, m_ci);
      check("R5 trim now", comp_now, m_cur);
      check("R5 seconds left", comp_left, m_cnt);
      check("R10 invalid flag", flag_invalid, m_inv);
      check("R8 overflow flag", flag_overflow, m_ovf);
      check("R9 alarm flag", flag_alarm, m_af);
      check("R3 pulse", sec_pulse, m_pulse);
    end
    if (sec_pulse) pulses.push_back(cyc);
    tick <= (cyc % tick_every) == 0;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
    end
  end

  task automatic wr_sec(logic [31:0] v);
    @(negedge clk); sec_wdata = v; sec_wr = 1; @(negedge clk); sec_wr = 0;
  endtask
  task automatic wr_alarm(logic [31:0] v);
    @(negedge clk); alarm_wdata = v; alarm_wr = 1; @(negedge clk); alarm_wr = 0;
  endtask
  task automatic wr_pre(logic [15:0] v);
    @(negedge clk); pre_wdata = v; pre_wr = 1; @(negedge clk); pre_wr = 0;
  endtask
  task automatic wr_comp(logic [7:0] v, logic [7:0] n);
    @(negedge clk); comp_val_wdata = v; comp_int_wdata = n; comp_wr = 1;
    @(negedge clk); comp_wr = 0;
  endtask
  task automatic wait_pulses(int n);
    while (pulses.size() < n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 invalid", flag_invalid, 1);
    check("R1 overflow", flag_overflow, 0);
    check("R1 alarm", flag_alarm, 0);
    check("R1 seconds", sec_rdata, 0);
    check("R1 prescaler", pre_rdata, 0);

    // R2: enabled but invalid, nothing counts
    count_en = 1;
    repeat (20) @(negedge clk);
    check("R2 halted while invalid", pre_rdata, 0);
    count_en = 0;

    wr_sec(32'd100);
    @(negedge clk);
    check("R10 load clears invalid", flag_invalid, 0);
    check("R10 seconds loaded", sec_rdata, 100);
    wr_alarm(32'd103);
    wr_pre(16'd0);
    wr_comp(8'h10, 8'd2);
    @(negedge clk);
    check("R6 trim now loaded", comp_now, 8'h10);
    check("R6 seconds left loaded", comp_left, 2);

    pulses.delete();
    count_en = 1;
    wr_sec(32'd5);
    wr_alarm(32'd7);
    wr_pre(16'd200);
    @(negedge clk);
    check("R10 write ignored when on", sec_rdata, 100);
    check("R11 write ignored when on", alarm_rdata, 103);
    check("R12 write ignored when on", pre_rdata < 16, 1);
    wait_pulses(6);
    check("R3 nominal gap", pulses[1] - pulses[0], 256);
    check("R5 untrimmed gap", pulses[2] - pulses[1], 256);
    check("R4 trimmed gap +16", pulses[3] - pulses[2], 240);
    check("R5 schedule repeats", pulses[4] - pulses[3], 256);
    check("R5 schedule repeats", pulses[5] - pulses[4], 256);
    check("R9 alarm reached", flag_alarm, 1);

    // Most negative trim, every second
    count_en = 0;
    wr_comp(8'h80, 8'd0);
    wr_pre(16'd0);
    @(negedge clk);
    check("R12 prescaler loaded", pre_rdata, 0);
    pulses.delete();
    count_en = 1;
    wait_pulses(3);
    check("R4 trim -128 gap", pulses[1] - pulses[0], 384);
    check("R4 trim -128 gap", pulses[2] - pulses[1], 384);

    // Trim -1 with tick every other cycle
    count_en = 0;
    tick_every = 2;
    wr_comp(8'hFF, 8'd0);
    wr_pre(16'd0);
    pulses.delete();
    count_en = 1;
    wait_pulses(3);
    check("R4 trim -1 sparse tick gap", pulses[1] - pulses[0], 514);
    check("R2 ticks not cycles", pulses[2] - pulses[1], 514);
    tick_every = 1;

    // Overflow
    count_en = 0;
    wr_comp(8'h00, 8'd0);
    wr_sec(32'hFFFF_FFFE);
    wr_pre(16'd250);
    pulses.delete();
    count_en = 1;
    wait_pulses(2);
    @(negedge clk);
    check("R8 overflow set", flag_overflow, 1);
    check("R7 reads zero", sec_rdata, 0);
    repeat (50) @(negedge clk);
    check("R8 counting halted", pre_rdata, 0);

    // Software reset
    @(negedge clk); soft_rst = 1; @(negedge clk); soft_rst = 0;
    @(negedge clk);
    check("R13 invalid after soft reset", flag_invalid, 1);
    check("R13 overflow cleared", flag_overflow, 0);
    check("R13 alarm reg cleared", alarm_rdata, 0);
    check("R13 trim cleared", comp_val_rdata, 0);
    count_en = 0;
    repeat (5) @(negedge clk);
    summary();
  end

endmodule